// File: doc/BRIEF.md
# Peripheral Write-Protection Gate

This block sits on a simple single-cycle register bus, in front of a group of peripherals. It keeps one lock bit per peripheral. A plain register write to a locked peripheral is stopped before it reaches the peripheral, and the requester gets an error response. A write tagged as a debugger access goes through whatever the lock state, and gets no error. Reads of peripherals are never stopped.

Software changes the lock bits through two aliases in a control window. A one written to the lock alias sets a bit. A one written to the unlock alias clears it. Zero bits change nothing, so no read-modify-write is needed. Both aliases read back the same lock vector. A write that would lock an already-locked peripheral, or unlock an already-unlocked one, is treated as a program-flow fault. Such a write applies no change at all and returns an error.

Every request gets a response exactly one cycle later. The error flag is a single-cycle pulse in that response cycle. The block only raises the flag; turning it into an exception is left to the surrounding system.

Top module: `periph_wp_ctrl`

## Requirements
- R1: After reset every lock bit is clear, and reading either alias returns zero with no error.
- R2: A write to the lock alias (control slot 32, byte offset 4) sets the lock bit for each one in wdata[N_PERIPH-1:0]. Zero bits leave their lock bits unchanged. There is no error if none of the targeted bits was already set.
- R3: A write to the unlock alias (control slot 32, byte offset 0) clears the lock bit for each one in wdata[N_PERIPH-1:0]. Zero bits leave their lock bits unchanged. There is no error if none of the targeted bits was already clear.
- R4: A read of the lock alias and a read of the unlock alias both return the current lock vector, zero-extended in rsp_rdata.
- R5: A non-debug write to peripheral slot n (address bits [15:10] = n, n < N_PERIPH) whose lock bit is set leaves fwd_sel all zero and raises rsp_err in the next cycle.
- R6: A write with req_debug high to a locked peripheral drives fwd_sel with only bit n set and gives no error.
- R7: A lock-alias write that has a one on an already-set bit raises rsp_err and changes no lock bit, including the bits in that write that were not yet set.
- R8: An unlock-alias write that has a one on an already-clear bit raises rsp_err and changes no lock bit.
- R9: A read of peripheral n always drives fwd_sel with only bit n set, raises no error, and returns the prd_data value of the request cycle in rsp_rdata one cycle later.
- R10: rsp_valid is high exactly in the cycle after each request. rsp_err is high only in such a cycle. fwd_sel has at most one bit set.
- R11: An access to a slot that is neither a peripheral nor the control slot is not forwarded. It raises rsp_err, and a read returns zero.
- R12: Lock-alias and unlock-alias wdata bits at N_PERIPH and above are ignored. Control-slot offsets other than 0 and 4 read zero, ignore writes and give no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_debug | input | 1 | Request comes from the debugger |
| req_addr | input | AW (16) | Byte address: slot in [15:10], offset in [9:0] |
| req_wdata | input | DW (32) | Write data |
| prd_data | input | DW (32) | Read data from the selected peripheral, same cycle |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Error pulse in the response cycle |
| rsp_rdata | output | DW (32) | Read data in the response cycle |
| fwd_sel | output | N_PERIPH (16) | One-hot select of the peripheral being accessed |
| fwd_write | output | 1 | Write strobe passed to peripherals |
| fwd_addr | output | SLOT_W (10) | Offset within the peripheral slot |
| fwd_wdata | output | DW (32) | Write data passed to peripherals |

## Verification
The lock-vector update and the judging of the next peripheral write can fall on adjacent edges. An alias write commits at the edge that ends its request cycle, and the very next request is gated by the new vector. The bench provokes this with back-to-back lock, write, unlock, write sequences and with a long stream of mixed requests that has no idle gaps. A behavioural model advances its lock vector at the same edge and judges fwd_sel in each request cycle and the response fields one cycle later. Writes that mix new and already-set bits test that a double lock or double unlock discards the whole write.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    // Classification of a bus request by the slot it addresses
    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_PERIPH   = 2'd1,
        ACC_CTRL     = 2'd2,
        ACC_UNMAPPED = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/wpc_decode.sv
module wpc_decode
    import wpc_pkg::*;
#(
    parameter int N_PERIPH  = 16,
    parameter int AW        = 16,
    parameter int SLOT_W    = 10,
    parameter int CTRL_SLOT = 32,
    parameter int CLR_OFS   = 0,
    parameter int SET_OFS   = 4
) (
    input  logic                req_valid,
    input  logic [AW-1:0]       req_addr,
    output acc_kind_e           kind,
    output logic [N_PERIPH-1:0] periph_oh,
    output logic                is_clr_alias,
    output logic                is_set_alias,
    output logic [SLOT_W-1:0]   offset
);
    localparam int IDX_W = AW - SLOT_W;

    logic [IDX_W-1:0] slot_idx;

    assign slot_idx = req_addr[AW-1:SLOT_W];
    assign offset   = req_addr[SLOT_W-1:0];

    always_comb begin
        if (!req_valid)
            kind = ACC_NONE;
        else if (int'(slot_idx) < N_PERIPH)
            kind = ACC_PERIPH;
        else if (int'(slot_idx) == CTRL_SLOT)
            kind = ACC_CTRL;
        else
            kind = ACC_UNMAPPED;
    end

    for (genvar g = 0; g < N_PERIPH; g++) begin : g_oh
        assign periph_oh[g] = (kind == ACC_PERIPH) && (int'(slot_idx) == g);
    end

    assign is_clr_alias = (kind == ACC_CTRL) && (int'(offset) == CLR_OFS);
    assign is_set_alias = (kind == ACC_CTRL) && (int'(offset) == SET_OFS);

endmodule

// File: rtl/wpc_prot_bank.sv
module wpc_prot_bank #(
    parameter int N_PERIPH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_wr,
    input  logic                clr_wr,
    input  logic [N_PERIPH-1:0] mask,
    output logic [N_PERIPH-1:0] prot,
    output logic                seq_err
);
    typedef struct packed {
        logic [N_PERIPH-1:0] lock;
    } bank_t;

    bank_t st_d, st_q;
    logic  dbl_set, dbl_clr;

    always_comb begin
        st_d    = st_q;
        dbl_set = set_wr && ((mask & st_q.lock) != '0);
        dbl_clr = clr_wr && ((mask & ~st_q.lock) != '0);
        if (set_wr && !dbl_set)
            st_d.lock = st_q.lock | mask;
        else if (clr_wr && !dbl_clr)
            st_d.lock = st_q.lock & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prot    = st_q.lock;
    assign seq_err = dbl_set || dbl_clr;

    // a successful lock write only ever adds bits
    AST_SET_ONLY_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && !seq_err) |=> ((prot & $past(prot)) == $past(prot))) else $error("set removed bits"); // R2

    // a successful unlock write only ever removes bits
    AST_CLR_ONLY_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !seq_err) |=> ((prot | $past(prot)) == $past(prot))) else $error("clear added bits"); // R3

endmodule

// File: rtl/wpc_gate.sv
module wpc_gate #(
    parameter int N_PERIPH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_write,
    input  logic                req_debug,
    input  logic [N_PERIPH-1:0] periph_oh,
    input  logic [N_PERIPH-1:0] prot,
    output logic [N_PERIPH-1:0] fwd_sel,
    output logic                blk_err
);
    logic hit_locked;

    always_comb begin
        hit_locked = (periph_oh & prot) != '0;
        blk_err    = req_write && !req_debug && hit_locked;
        fwd_sel    = blk_err ? '0 : periph_oh;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_sel)) else $error("fwd_sel not one-hot"); // R10

endmodule

// File: rtl/periph_wp_ctrl.sv
module periph_wp_ctrl
    import wpc_pkg::*;
#(
    parameter int N_PERIPH  = 16,
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int SLOT_W    = 10,
    parameter int CTRL_SLOT = 32,
    parameter int CLR_OFS   = 0,
    parameter int SET_OFS   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_debug,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    input  logic [DW-1:0]       prd_data,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DW-1:0]       rsp_rdata,
    output logic [N_PERIPH-1:0] fwd_sel,
    output logic                fwd_write,
    output logic [SLOT_W-1:0]   fwd_addr,
    output logic [DW-1:0]       fwd_wdata
);
    typedef struct packed {
        logic          valid;
        logic          err;
        logic [DW-1:0] rdata;
    } rsp_t;

    acc_kind_e           kind;
    logic [N_PERIPH-1:0] periph_oh;
    logic                is_clr_alias, is_set_alias;
    logic [SLOT_W-1:0]   offset;
    logic [N_PERIPH-1:0] prot;
    logic                seq_err, blk_err;
    logic                set_wr, clr_wr;
    rsp_t                rsp_d, rsp_q;

    wpc_decode #(
        .N_PERIPH (N_PERIPH), .AW (AW), .SLOT_W (SLOT_W),
        .CTRL_SLOT(CTRL_SLOT), .CLR_OFS(CLR_OFS), .SET_OFS(SET_OFS)
    ) u_decode (
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .kind        (kind),
        .periph_oh   (periph_oh),
        .is_clr_alias(is_clr_alias),
        .is_set_alias(is_set_alias),
        .offset      (offset)
    );

    assign set_wr = is_set_alias && req_write;
    assign clr_wr = is_clr_alias && req_write;

    wpc_prot_bank #(.N_PERIPH(N_PERIPH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (set_wr),
        .clr_wr (clr_wr),
        .mask   (req_wdata[N_PERIPH-1:0]),
        .prot   (prot),
        .seq_err(seq_err)
    );

    wpc_gate #(.N_PERIPH(N_PERIPH)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_write(req_write),
        .req_debug(req_debug),
        .periph_oh(periph_oh),
        .prot     (prot),
        .fwd_sel  (fwd_sel),
        .blk_err  (blk_err)
    );

    assign fwd_write = req_write;
    assign fwd_addr  = offset;
    assign fwd_wdata = req_wdata;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        unique case (kind)
            ACC_PERIPH: begin
                rsp_d.err = blk_err;
                if (!req_write) rsp_d.rdata = prd_data;
            end
            ACC_CTRL: begin
                rsp_d.err = seq_err;
                if (!req_write && (is_clr_alias || is_set_alias))
                    rsp_d.rdata[N_PERIPH-1:0] = prot;
            end
            ACC_UNMAPPED: rsp_d.err = 1'b1;
            default:      rsp_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("missing response"); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err)) else $error("spurious response"); // R10

    AST_LOCKED_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_debug && kind == ACC_PERIPH && (periph_oh & prot) != '0)
        |-> (fwd_sel == '0)) else $error("locked write forwarded"); // R5

    AST_LOCKED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_debug && kind == ACC_PERIPH && (periph_oh & prot) != '0)
        |=> rsp_err) else $error("locked write without error"); // R5

    AST_DEBUG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_debug && kind == ACC_PERIPH)
        |-> (fwd_sel == periph_oh)) else $error("debug write blocked"); // R6

    AST_DEBUG_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_debug && kind == ACC_PERIPH)
        |=> !rsp_err) else $error("debug write errored"); // R6

    AST_DBL_SET_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && (req_wdata[N_PERIPH-1:0] & prot) != '0)
        |=> ($stable(prot) && rsp_err)) else $error("double lock not rejected"); // R7

    AST_DBL_CLR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && (req_wdata[N_PERIPH-1:0] & ~prot) != '0)
        |=> ($stable(prot) && rsp_err)) else $error("double unlock not rejected"); // R8

    AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && kind == ACC_PERIPH)
        |-> (fwd_sel == periph_oh)) else $error("read blocked"); // R9

    AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_UNMAPPED) |=> (rsp_err && rsp_rdata == '0)) else $error("unmapped not flagged"); // R11

endmodule

// File: tb/periph_wp_ctrl_bench.sv
module periph_wp_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_debug = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0, prd_data = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [15:0] fwd_sel;
    logic        fwd_write;
    logic [9:0]  fwd_addr;
    logic [31:0] fwd_wdata;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [15:0] m_lock = '0;
    logic        e_valid = 1'b0, e_err = 1'b0;
    logic [31:0] e_rdata = '0;

    always #2 clk = ~clk;

    periph_wp_ctrl u_periph_wp_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_debug(req_debug),
        .req_addr(req_addr), .req_wdata(req_wdata), .prd_data(prd_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .fwd_sel(fwd_sel), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
        .fwd_wdata(fwd_wdata)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pa(input int slot, input int ofs);
        return 16'(slot * 1024 + ofs);
    endfunction

    // One bus cycle: judge the previous response, drive, judge forwarding, advance model
    task automatic step(input logic v, input logic w, input logic d, input logic [15:0] a,
                        input logic [31:0] wd, input logic [31:0] pd, input string tag);
        int          slot, ofs;
        logic [15:0] e_sel, mask;
        logic        n_err;
        logic [31:0] n_rdata;
        @(negedge clk);
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'(e_valid));
        chk(tag, "rsp_err",   64'(rsp_err),   64'(e_err));
        chk(tag, "rsp_rdata", 64'(rsp_rdata), 64'(e_rdata));
        req_valid = v; req_write = w; req_debug = d;
        req_addr = a; req_wdata = wd; prd_data = pd;
        #1;
        slot = int'(a) / 1024;
        ofs  = int'(a) % 1024;
        mask = wd[15:0];
        e_sel = '0; n_err = 1'b0; n_rdata = '0;
        if (v) begin
            if (slot < 16) begin
                if (!w || d || !m_lock[slot]) e_sel[slot] = 1'b1;
                n_err = w && !d && m_lock[slot];
                if (!w) n_rdata = pd;
            end else if (slot == 32) begin
                if (!w) begin
                    if (ofs == 0 || ofs == 4) n_rdata = {16'h0, m_lock};
                end else if (ofs == 4) begin
                    if ((mask & m_lock) != 0) n_err = 1'b1;
                    else m_lock = m_lock | mask;
                end else if (ofs == 0) begin
                    if ((mask & ~m_lock) != 0) n_err = 1'b1;
                    else m_lock = m_lock & ~mask;
                end
            end else begin
                n_err = 1'b1;
            end
        end
        chk(tag, "fwd_sel", 64'(fwd_sel), 64'(e_sel));
        if (v && e_sel != 0) begin
            chk(tag, "fwd_addr",  64'(fwd_addr),  64'(ofs));
            chk(tag, "fwd_wdata", 64'(fwd_wdata), 64'(wd));
            chk(tag, "fwd_write", 64'(fwd_write), 64'(w));
        end
        e_valid = v; e_err = n_err; e_rdata = n_rdata;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 1'b0, '0, '0, '0, tag);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state through both aliases
        step(1'b1, 1'b0, 1'b0, pa(32, 0), '0, 32'hDEAD, "R1");
        step(1'b1, 1'b0, 1'b0, pa(32, 4), '0, 32'hDEAD, "R1");
        idle("R10");
        // unlocked write is forwarded
        step(1'b1, 1'b1, 1'b0, pa(3, 8), 32'h1234, '0, "R5");
        // R2: lock peripherals 0 and 3, then R4: both aliases agree
        step(1'b1, 1'b1, 1'b0, pa(32, 4), 32'h0009, '0, "R2");
        step(1'b1, 1'b0, 1'b0, pa(32, 4), '0, '0, "R4");
        step(1'b1, 1'b0, 1'b0, pa(32, 0), '0, '0, "R4");
        // R5: locked write is blocked
        step(1'b1, 1'b1, 1'b0, pa(3, 12), 32'hAAAA, '0, "R5");
        // R9: read of locked peripheral passes
        step(1'b1, 1'b0, 1'b0, pa(3, 12), '0, 32'hCAFE_F00D, "R9");
        // R6: debug write to locked peripheral passes
        step(1'b1, 1'b1, 1'b1, pa(0, 4), 32'h55, '0, "R6");
        // R7: double lock rejects the whole write (bit 1 is new, bit 0 is not)
        step(1'b1, 1'b1, 1'b0, pa(32, 4), 32'h0003, '0, "R7");
        step(1'b1, 1'b0, 1'b0, pa(32, 4), '0, '0, "R7");
        // R8: double unlock rejects the whole write (bit 3 set, bit 1 clear)
        step(1'b1, 1'b1, 1'b0, pa(32, 0), 32'h000A, '0, "R8");
        step(1'b1, 1'b0, 1'b0, pa(32, 0), '0, '0, "R8");
        // R3: unlock peripheral 3, then write it back-to-back
        step(1'b1, 1'b1, 1'b0, pa(32, 0), 32'h0008, '0, "R3");
        step(1'b1, 1'b1, 1'b0, pa(3, 0), 32'h77, '0, "R3");
        step(1'b1, 1'b0, 1'b0, pa(32, 4), '0, '0, "R3");
        // R11: unmapped slots
        step(1'b1, 1'b1, 1'b0, pa(20, 0), 32'h1, '0, "R11");
        step(1'b1, 1'b0, 1'b0, pa(63, 4), '0, 32'hFFFF_FFFF, "R11");
        // R12: high mask bits ignored, other control offsets inert
        step(1'b1, 1'b1, 1'b0, pa(32, 4), 32'hFFFF_0010, '0, "R12");
        step(1'b1, 1'b0, 1'b0, pa(32, 0), '0, '0, "R12");
        step(1'b1, 1'b1, 1'b0, pa(32, 8), 32'hFFFF_FFFF, '0, "R12");
        step(1'b1, 1'b0, 1'b0, pa(32, 8), '0, '0, "R12");
        step(1'b1, 1'b0, 1'b0, pa(32, 4), '0, '0, "R12");
        // lock then write back-to-back
        step(1'b1, 1'b1, 1'b0, pa(32, 4), 32'h0100, '0, "R2");
        step(1'b1, 1'b1, 1'b0, pa(8, 0), 32'h9, '0, "R5");
        idle("R10");
        // mixed stream, no gaps
        for (int i = 0; i < 600; i++) begin
            int          op;
            logic [31:0] r;
            op = int'($urandom % 8);
            r  = $urandom;
            case (op)
                0, 1: step(1'b1, 1'b1, r[20], pa(int'(r[3:0]), int'(r[9:2]) * 4), r, '0, "R5");
                2:    step(1'b1, 1'b0, 1'b0, pa(int'(r[3:0]), 0), '0, r, "R9");
                3:    step(1'b1, 1'b1, 1'b0, pa(32, 4), 32'(1) << r[3:0] | (r[31] ? 32'(1) << r[7:4] : 32'h0), '0, "R7");
                4:    step(1'b1, 1'b1, 1'b0, pa(32, 0), 32'(1) << r[3:0] | (r[31] ? 32'(1) << r[7:4] : 32'h0), '0, "R8");
                5:    step(1'b1, 1'b0, 1'b0, pa(32, r[0] ? 4 : 0), '0, '0, "R4");
                6:    step(1'b1, r[0], 1'b0, pa(16 + int'(r[3:0]), 0), r, r, "R11");
                default: idle("R10");
            endcase
        end
        idle("R10");
        idle("R10");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule